// File: doc/BRIEF.md
# Banked Index/Data Configuration Register File

This block holds the configuration registers that a host programs through a pair of adjacent byte-wide I/O ports. A write to the even address of the pair loads a register index; the odd address then reads or writes the register that index selects. One index holds a logical device number. That number picks which per-device bank answers at the per-device indices. A separate range of global registers answers the same way whatever device is selected.

Each supported device has its own bank. A bank holds an enable bit, a command port base and a data port base (each a high/low byte pair), two interrupt selection bytes and sixteen device-specific bytes. The block drives each device's enable and its two 16-bit port bases to the host modules that decode those ports. A lock input lets the core side fence off host access while it works on the registers itself.

Top module: `cfg_regfile`

## Requirements
- R1: A write to address BASE_ADDR (bit 0 clear, default 0x004E) loads the index register; a read there returns the index.
- R2: Index 0x07 holds the logical device number, which reads back through the data port at BASE_ADDR+1.
- R3: Indices 0x20 to 0x2F are sixteen global byte registers that read and write the same storage whatever the device number.
- R4: Indices 0x30, 0x60 to 0x63, 0x70, 0x71 and 0xF0 to 0xFF reach the bank of the selected device. The supported device numbers are 0x05, 0x06, 0x0F, 0x11 and 0x12, and they map to output slot 0 to 4 in that order. Each bank keeps its values while another bank is selected.
- R5: Bit 0 of index 0x30 is the device enable and drives dev_en for that slot; the other bits of index 0x30 read as 0.
- R6: An enabled slot drives dev_cmd_base as {index 0x60, index 0x61} and dev_data_base as {index 0x62, index 0x63}, in 16-bit field 16*slot; a disabled slot drives both as 0.
- R7: Any other index (including 0x72 to 0x74) reads 0x00 through the data port, and writes to it change nothing.
- R8: With an unsupported device number selected, per-device indices read 0x00 and writes to them change no bank.
- R9: While cfg_lock is high, host reads and writes are ignored: no register and no read data changes.
- R10: Accesses to addresses other than BASE_ADDR and BASE_ADDR+1 are ignored.
- R11: Reset clears every register, including the index, the device number and host_rdata, to 0.
- R12: Read data is registered: it appears on host_rdata in the cycle after the read strobe and holds until the next accepted read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 16 | Host I/O address |
| host_wr | input | 1 | Host write strobe, one cycle per byte |
| host_rd | input | 1 | Host read strobe, one cycle per byte |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered read byte |
| cfg_lock | input | 1 | Blocks host access while high |
| dev_en | output | 5 | Per-slot device enable |
| dev_cmd_base | output | 80 | Per-slot command port base, 16 bits per slot |
| dev_data_base | output | 80 | Per-slot data port base, 16 bits per slot |

## Verification
The lock and a host access can land in the same cycle. The bench raises cfg_lock together with writes to both ports and with reads, at random and in directed cases. It then judges the result by reading back the index, the device number and the banked values after the lock drops. A change of device number takes effect on the very next data-port access, so the bench switches banks back to back. It checks that the following write or read reaches the new bank.

// File: rtl/cfg_regfile_pkg.sv
package cfg_regfile_pkg;

    localparam int NUM_DEV   = 5;
    localparam int BASE_W    = 16;
    localparam int NUM_GLOB  = 16;
    localparam int NUM_IO    = 4;
    localparam int NUM_IRQ   = 2;
    localparam int NUM_SPEC  = 16;

    localparam logic [7:0] DEV_LDN [NUM_DEV] = '{8'h05, 8'h06, 8'h0F, 8'h11, 8'h12};

    localparam logic [7:0] IDX_LDN  = 8'h07;
    localparam logic [7:0] IDX_CTRL = 8'h30;

    typedef enum logic [2:0] {
        K_NONE,
        K_LDN,
        K_GLOB,
        K_CTRL,
        K_IO,
        K_IRQ,
        K_SPEC
    } idx_kind_e;

    typedef struct packed {
        logic                      en;
        logic [NUM_IO-1:0][7:0]    io;
        logic [NUM_IRQ-1:0][7:0]   irq;
        logic [NUM_SPEC-1:0][7:0]  spec;
    } bank_t;

    typedef struct packed {
        logic [7:0]                idx;
        logic [7:0]                ldn;
        logic [NUM_GLOB-1:0][7:0]  glob;
        logic [7:0]                rdata;
    } top_t;

endpackage

// File: rtl/cfg_index_decode.sv
module cfg_index_decode
    import cfg_regfile_pkg::*;
(
    input  logic [7:0] idx,
    output idx_kind_e  kind,
    output logic [3:0] off
);
    always_comb begin
        kind = K_NONE;
        off  = idx[3:0];
        if (idx == IDX_LDN)                           kind = K_LDN;
        else if (idx[7:4] == 4'h2)                    kind = K_GLOB;
        else if (idx == IDX_CTRL)                     kind = K_CTRL;
        else if (idx[7:2] == 6'b0110_00)              kind = K_IO;
        else if (idx[7:1] == 7'b0111_000)             kind = K_IRQ;
        else if (idx[7:4] == 4'hF)                    kind = K_SPEC;
    end
endmodule

// File: rtl/cfg_dev_bank.sv
module cfg_dev_bank
    import cfg_regfile_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  idx_kind_e         kind,
    input  logic [3:0]        off,
    input  logic [7:0]        wdata,
    output logic [7:0]        rd_data,
    output logic              en,
    output logic [BASE_W-1:0] cmd_base,
    output logic [BASE_W-1:0] data_base
);
    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (wr_en) begin
            unique case (kind)
                K_CTRL:  bank_d.en              = wdata[0];
                K_IO:    bank_d.io[off[1:0]]    = wdata;
                K_IRQ:   bank_d.irq[off[0]]     = wdata;
                K_SPEC:  bank_d.spec[off]       = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    always_comb begin
        unique case (kind)
            K_CTRL:  rd_data = {7'b0, bank_q.en};
            K_IO:    rd_data = bank_q.io[off[1:0]];
            K_IRQ:   rd_data = bank_q.irq[off[0]];
            K_SPEC:  rd_data = bank_q.spec[off];
            default: rd_data = 8'h00;
        endcase
    end

    // high byte sits at the lower index of each pair
    assign en        = bank_q.en;
    assign cmd_base  = bank_q.en ? {bank_q.io[0], bank_q.io[1]} : '0;
    assign data_base = bank_q.en ? {bank_q.io[2], bank_q.io[3]} : '0;
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
    import cfg_regfile_pkg::*;
#(
    parameter int               ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h004E
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           host_addr,
    input  logic                        host_wr,
    input  logic                        host_rd,
    input  logic [7:0]                  host_wdata,
    output logic [7:0]                  host_rdata,
    input  logic                        cfg_lock,
    output logic [NUM_DEV-1:0]          dev_en,
    output logic [NUM_DEV*BASE_W-1:0]   dev_cmd_base,
    output logic [NUM_DEV*BASE_W-1:0]   dev_data_base
);
    top_t st_d, st_q;

    logic [7:0]       idx_q, ldn_q;
    idx_kind_e        kind;
    logic [3:0]       off;
    logic             hit, acc_wr, acc_rd, data_port, banked;
    logic [NUM_DEV-1:0] sel;
    logic [7:0]       bank_rd [NUM_DEV];
    logic [7:0]       banked_rd;
    logic [7:0]       data_val;

    assign idx_q = st_q.idx;
    assign ldn_q = st_q.ldn;

    assign hit       = (host_addr[ADDR_W-1:1] == BASE_ADDR[ADDR_W-1:1]) && !cfg_lock;
    assign acc_wr    = hit && host_wr;
    assign acc_rd    = hit && host_rd;
    assign data_port = host_addr[0];
    assign banked    = (kind == K_CTRL) || (kind == K_IO) || (kind == K_IRQ) || (kind == K_SPEC);

    cfg_index_decode u_dec (
        .idx  (idx_q),
        .kind (kind),
        .off  (off)
    );

    genvar g;
    generate
        for (g = 0; g < NUM_DEV; g++) begin : g_bank
            assign sel[g] = (ldn_q == DEV_LDN[g]);
            cfg_dev_bank u_bank (
                .clk       (clk),
                .rst_n     (rst_n),
                .wr_en     (acc_wr && data_port && sel[g] && banked),
                .kind      (kind),
                .off       (off),
                .wdata     (host_wdata),
                .rd_data   (bank_rd[g]),
                .en        (dev_en[g]),
                .cmd_base  (dev_cmd_base[g*BASE_W +: BASE_W]),
                .data_base (dev_data_base[g*BASE_W +: BASE_W])
            );
        end
    endgenerate

    always_comb begin
        banked_rd = 8'h00;
        for (int i = 0; i < NUM_DEV; i++) begin
            if (sel[i]) banked_rd = banked_rd | bank_rd[i];
        end
    end

    always_comb begin
        unique case (kind)
            K_LDN:                     data_val = st_q.ldn;
            K_GLOB:                    data_val = st_q.glob[off];
            K_CTRL, K_IO, K_IRQ, K_SPEC: data_val = banked_rd;
            default:                   data_val = 8'h00;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (acc_wr) begin
            if (!data_port) begin
                st_d.idx = host_wdata;
            end else if (kind == K_LDN) begin
                st_d.ldn = host_wdata;
            end else if (kind == K_GLOB) begin
                st_d.glob[off] = host_wdata;
            end
        end
        if (acc_rd) begin
            st_d.rdata = data_port ? data_val : st_q.idx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign host_rdata = st_q.rdata;
endmodule

// File: rtl/cfg_regfile_chk.sv
module cfg_regfile_chk
    import cfg_regfile_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h004E
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [ADDR_W-1:0]         host_addr,
    input logic                      host_wr,
    input logic                      host_rd,
    input logic [7:0]                host_rdata,
    input logic                      cfg_lock,
    input logic [NUM_DEV-1:0]        dev_en,
    input logic [NUM_DEV*BASE_W-1:0] dev_cmd_base,
    input logic [NUM_DEV*BASE_W-1:0] dev_data_base,
    input logic [7:0]                idx_q,
    input logic [7:0]                ldn_q
);
    logic outside;
    assign outside = host_addr[ADDR_W-1:1] != BASE_ADDR[ADDR_W-1:1];

    p_lock_idx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_lock |=> $stable(idx_q) && $stable(ldn_q) && $stable(dev_en));

    p_lock_rdata_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_lock |=> $stable(host_rdata));

    p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> $stable(host_rdata));

    p_outside_r10: assert property (@(posedge clk) disable iff (!rst_n)
        outside |=> $stable(idx_q) && $stable(ldn_q) && $stable(host_rdata)
                    && $stable(dev_cmd_base) && $stable(dev_data_base));

    p_idx_only_port_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_wr && !cfg_lock && !outside && !host_addr[0]) |=> $stable(idx_q));

    genvar g;
    generate
        for (g = 0; g < NUM_DEV; g++) begin : g_en
            p_base_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
                !dev_en[g] |-> (dev_cmd_base[g*BASE_W +: BASE_W] == '0)
                             && (dev_data_base[g*BASE_W +: BASE_W] == '0));
        end
    endgenerate
endmodule

bind cfg_regfile cfg_regfile_chk #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_addr    (host_addr),
    .host_wr      (host_wr),
    .host_rd      (host_rd),
    .host_rdata   (host_rdata),
    .cfg_lock     (cfg_lock),
    .dev_en       (dev_en),
    .dev_cmd_base (dev_cmd_base),
    .dev_data_base(dev_data_base),
    .idx_q        (idx_q),
    .ldn_q        (ldn_q)
);

// File: tb/cfg_regfile_test.sv
module cfg_regfile_test;
    localparam int ND = 5;
    localparam logic [15:0] BASE = 16'h004E;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] host_addr = '0;
    logic        host_wr = 1'b0, host_rd = 1'b0, cfg_lock = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic [ND-1:0]    dev_en;
    logic [ND*16-1:0] dev_cmd_base, dev_data_base;

    cfg_regfile uut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .cfg_lock(cfg_lock), .dev_en(dev_en), .dev_cmd_base(dev_cmd_base),
        .dev_data_base(dev_data_base)
    );

    always #5 clk = ~clk;

    int checks = 0, fails = 0;
    bit done = 0;

    // bench model
    logic [7:0] m_idx, m_ldn, m_rdata;
    logic [7:0] m_glob [16];
    logic       m_en   [ND];
    logic [7:0] m_io   [ND][4];
    logic [7:0] m_irq  [ND][2];
    logic [7:0] m_spec [ND][16];
    logic [7:0] ldns [ND] = '{8'h05, 8'h06, 8'h0F, 8'h11, 8'h12};
    logic [7:0] pick_idx [20] = '{8'h07, 8'h20, 8'h2F, 8'h25, 8'h30, 8'h60, 8'h61, 8'h62,
                                  8'h63, 8'h70, 8'h71, 8'h72, 8'h73, 8'h74, 8'hF0, 8'hFF,
                                  8'hF7, 8'h00, 8'h31, 8'h64};
    logic [7:0] pick_ldn [6] = '{8'h05, 8'h06, 8'h0F, 8'h11, 8'h12, 8'h07};

    function automatic int dev_of(logic [7:0] l);
        for (int i = 0; i < ND; i++) if (ldns[i] == l) return i;
        return -1;
    endfunction

    function automatic logic [7:0] exp_data();
        int d = dev_of(m_idx == m_idx ? m_ldn : m_ldn);
        if (m_idx == 8'h07) return m_ldn;
        if (m_idx[7:4] == 4'h2) return m_glob[m_idx[3:0]];
        if (d < 0) return 8'h00;
        if (m_idx == 8'h30) return {7'b0, m_en[d]};
        if (m_idx >= 8'h60 && m_idx <= 8'h63) return m_io[d][m_idx[1:0]];
        if (m_idx == 8'h70 || m_idx == 8'h71) return m_irq[d][m_idx[0]];
        if (m_idx[7:4] == 4'hF) return m_spec[d][m_idx[3:0]];
        return 8'h00;
    endfunction

    function automatic void model_write(logic [15:0] a, logic [7:0] v);
        int d = dev_of(m_ldn);
        if (a[15:1] != BASE[15:1]) return;
        if (!a[0]) begin m_idx = v; return; end
        if (m_idx == 8'h07) m_ldn = v;
        else if (m_idx[7:4] == 4'h2) m_glob[m_idx[3:0]] = v;
        else if (d >= 0) begin
            if (m_idx == 8'h30) m_en[d] = v[0];
            else if (m_idx >= 8'h60 && m_idx <= 8'h63) m_io[d][m_idx[1:0]] = v;
            else if (m_idx == 8'h70 || m_idx == 8'h71) m_irq[d][m_idx[0]] = v;
            else if (m_idx[7:4] == 4'hF) m_spec[d][m_idx[3:0]] = v;
        end
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_outs(string tag);
        for (int i = 0; i < ND; i++) begin
            check({tag, " R5 en"}, 32'(dev_en[i]), 32'(m_en[i]));
            check({tag, " R6 cmd"}, 32'(dev_cmd_base[i*16 +: 16]),
                  m_en[i] ? 32'({m_io[i][0], m_io[i][1]}) : 32'd0);
            check({tag, " R6 data"}, 32'(dev_data_base[i*16 +: 16]),
                  m_en[i] ? 32'({m_io[i][2], m_io[i][3]}) : 32'd0);
        end
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] v, logic lk);
        @(negedge clk);
        host_addr = a; host_wdata = v; host_wr = 1'b1; cfg_lock = lk;
        @(negedge clk);
        host_wr = 1'b0; cfg_lock = 1'b0;
        if (!lk) model_write(a, v);
    endtask

    task automatic rd(logic [15:0] a, logic lk, string tag);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1; cfg_lock = lk;
        @(negedge clk);
        host_rd = 1'b0; cfg_lock = 1'b0;
        if (!lk && a[15:1] == BASE[15:1]) m_rdata = a[0] ? exp_data() : m_idx;
        check(tag, 32'(host_rdata), 32'(m_rdata));
    endtask

    task automatic reg_wr(logic [7:0] i, logic [7:0] v);
        wr(BASE, i, 1'b0);
        wr(BASE + 16'd1, v, 1'b0);
    endtask

    task automatic reg_rd(logic [7:0] i, string tag);
        wr(BASE, i, 1'b0);
        rd(BASE + 16'd1, 1'b0, tag);
    endtask

    initial begin
        for (int c = 0; c < 200000; c++) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        m_idx = 0; m_ldn = 0; m_rdata = 0;
        for (int i = 0; i < 16; i++) m_glob[i] = 0;
        for (int d = 0; d < ND; d++) begin
            m_en[d] = 0;
            for (int k = 0; k < 4; k++) m_io[d][k] = 0;
            for (int k = 0; k < 2; k++) m_irq[d][k] = 0;
            for (int k = 0; k < 16; k++) m_spec[d][k] = 0;
        end
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        check("R11 rdata", 32'(host_rdata), 0);
        check_outs("R11");
        rd(BASE, 1'b0, "R11 idx");
        rd(BASE + 16'd1, 1'b0, "R11 data");

        // R1 index readback
        wr(BASE, 8'hA5, 1'b0);
        rd(BASE, 1'b0, "R1 idx");
        // R2 device number
        reg_wr(8'h07, 8'h06);
        reg_rd(8'h07, "R2 ldn");
        // R5/R6 enable and bases for keyboard slot
        reg_wr(8'h60, 8'h02); reg_wr(8'h61, 8'h00);
        reg_wr(8'h62, 8'h02); reg_wr(8'h63, 8'h04);
        check_outs("R6 pre-enable");
        reg_wr(8'h30, 8'hFF);
        reg_rd(8'h30, "R5 ctrl");
        check_outs("R6 enabled");
        // R4 bank switch back to back
        reg_wr(8'h07, 8'h12);
        rd(BASE + 16'd1, 1'b0, "R2 switch");
        reg_rd(8'h60, "R4 other bank");
        reg_wr(8'h60, 8'h33);
        reg_wr(8'h07, 8'h06);
        reg_rd(8'h60, "R4 kept");
        // R3 globals independent of device
        reg_wr(8'h2F, 8'h5A);
        reg_wr(8'h07, 8'h0F);
        reg_rd(8'h2F, "R3 global");
        // R7 unimplemented
        reg_wr(8'h73, 8'h77);
        reg_rd(8'h73, "R7 dma");
        reg_rd(8'h72, "R7 gap");
        // R8 unsupported device
        reg_wr(8'h07, 8'h07);
        reg_wr(8'hF3, 8'h99);
        reg_rd(8'hF3, "R8 unsup");
        reg_wr(8'h07, 8'h0F);
        reg_rd(8'hF3, "R8 no bank touched");
        // R9 lock collides with writes and reads
        wr(BASE, 8'h30, 1'b1);
        rd(BASE, 1'b0, "R9 idx locked");
        wr(BASE + 16'd1, 8'h01, 1'b1);
        check_outs("R9 locked ctrl");
        rd(BASE, 1'b1, "R9 rdata locked");
        // R10 outside addresses
        wr(16'h004C, 8'h11, 1'b0);
        wr(16'h014E, 8'h22, 1'b0);
        rd(BASE, 1'b0, "R10 idx");
        // R12 hold
        repeat (4) @(negedge clk);
        check("R12 hold", 32'(host_rdata), 32'(m_rdata));

        // random mix
        for (int n = 0; n < 1500; n++) begin
            int op = $urandom_range(0, 9);
            logic lk = ($urandom_range(0, 9) == 0);
            logic [15:0] a = ($urandom_range(0, 19) == 0) ? 16'h0050 : BASE;
            if (op < 3) wr(a, pick_idx[$urandom_range(0, 19)], lk);
            else if (op < 4) begin
                wr(BASE, 8'h07, 1'b0);
                wr(a + 16'd1, pick_ldn[$urandom_range(0, 5)], lk);
            end else if (op < 7) wr(a + 16'd1, 8'($urandom), lk);
            else rd(a + 16'(op & 1), lk, "R4 random read");
            if (n % 8 == 0) check_outs("R6 random");
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule